// File: doc/BRIEF.md
# Programmable Clock Divider with Selectable Divisor Encodings

This block derives an output clock from its single input clock by an integer divisor. Software writes a 32-bit control word through a small write port. The divisor field inside that word sits under a fixed mask at a fixed shift. The block reads the field according to an encoding that is picked on a 3-bit mode input. Four encodings are arithmetic: field plus one, field as is, two to the power of the field, and field as is with zero also giving one. The fifth uses a small lookup table. Software fills the table through the same port, and each entry pairs a field value with a divisor.

The encoding is applied when the control word is written. A legal result becomes the pending divisor. The running divider takes the pending divisor only when its current output period has finished, so the output never shows a shortened phase. An illegal result leaves the pending divisor as it was and sets a sticky error output. The output is never gated. With a divisor of one, the input clock passes straight through.

Top module: `prog_clk_div`

## Requirements
- R1: After reset the output is the input clock (divide-by-1), every table entry is empty, and err_o is 0.
- R2: The field is the low DIV_W bits of ((wr_data_i >> SHIFT) & MASK). The defaults are SHIFT=4, MASK=0xFF and DIV_W=8, so the field is bits [11:4]. Control bits outside the mask have no effect.
- R3: With mode_i 0 (and also 5, 6 or 7), the divisor is field+1.
- R4: With mode_i 1, the divisor equals the field. A field of 0 is rejected: the divisor is kept and err_o is set.
- R5: With mode_i 2, the divisor is 2 to the power of the field. A field greater than DIV_W is rejected: the divisor is kept and err_o is set.
- R6: With mode_i 3, a field of 0 gives divide-by-1. Any other field gives divide-by-field.
- R7: With mode_i 4, the divisor comes from the table. Address i+1 (for i from 0 to TBL_N-1) writes entry i. In each entry word, bit 31 is valid, bits [24:16] are the divisor and bits [7:0] are the field. The entry with the lowest index whose field matches wins. Entries that are not valid, or that hold divisor 0, never match.
- R8: In mode 4, a field with no matching entry keeps the current divisor. err_o goes to 1 on the clock edge that takes the write and stays 1 until reset.
- R9: For a divisor N of 2 or more, the output period is N input cycles. The high phase is floor(N/2) cycles and starts the period.
- R10: A new divisor starts only after the current output period has ended. Every high or low phase on the output has the length that belongs to the old divisor or to the new one.
- R11: Writes to addresses above TBL_N change neither the table nor the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, the only clock of the block |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| wr_en_i | input | 1 | Write strobe for the register port |
| wr_addr_i | input | AW (4) | Write address: 0 is the control word, 1..TBL_N are table entries |
| wr_data_i | input | 32 | Write data |
| mode_i | input | 3 | Divisor encoding, sampled with a control-word write |
| clk_o | output | 1 | Divided output clock |
| err_o | output | 1 | Sticky flag for a rejected control word |

## Verification
The hardest case to reach is a divisor change that lands in the middle of a long output period. Only the lengths of the phases that follow show whether the old period ran to its end. The bench first settles the divider at divide-by-8. It then writes divide-by-2 a few cycles into a period and records the length of every complete high and low run after that. Each run must be 4 or 1. Table misses are reached in two ways: through a field that only an entry marked invalid carries, and through a field that was written only to an ignored address. In both cases the divisor must still be the old one.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Encoding codes on mode_i; codes 5..7 fall back to minus-one
    localparam logic [2:0] ENC_MINUS1  = 3'd0;
    localparam logic [2:0] ENC_ONEBASE = 3'd1;
    localparam logic [2:0] ENC_POW2    = 3'd2;
    localparam logic [2:0] ENC_ZERO1   = 3'd3;
    localparam logic [2:0] ENC_LOOKUP  = 3'd4;

    // Table entry word layout
    localparam int unsigned TBL_VLD_BIT = 31;
    localparam int unsigned TBL_DIV_LSB = 16;

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned TBL_N = 8,
    parameter int unsigned SHIFT = 4,
    parameter logic [31:0] MASK  = 32'h0000_00FF,
    localparam int unsigned DW   = DIV_W + 1
) (
    input  logic [31:0]                     ctrl_i,
    input  logic [2:0]                      mode_i,
    input  logic [TBL_N-1:0]                vld_i,
    input  logic [TBL_N-1:0][DIV_W-1:0]     fld_i,
    input  logic [TBL_N-1:0][DW-1:0]        dv_i,
    output logic [DW-1:0]                   div_o,
    output logic                            ok_o
);

    logic [31:0]      raw;
    logic [DIV_W-1:0] fld;
    logic [TBL_N-1:0] hit;
    logic [DW-1:0]    tbl_div;
    logic             tbl_hit;
    logic             unused_raw;

    assign raw        = (ctrl_i >> SHIFT) & MASK;
    assign fld        = raw[DIV_W-1:0];
    assign unused_raw = ^raw[31:DIV_W];

    // One comparator per table entry
    for (genvar g = 0; g < TBL_N; g++) begin : g_match
        assign hit[g] = vld_i[g] && (fld_i[g] == fld) && (dv_i[g] != '0);
    end

    // Lowest index wins
    always_comb begin
        tbl_hit = 1'b0;
        tbl_div = '0;
        for (int i = TBL_N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                tbl_hit = 1'b1;
                tbl_div = dv_i[i];
            end
        end
    end

    always_comb begin
        div_o = DW'(1);
        ok_o  = 1'b1;
        case (mode_i)
            ENC_ONEBASE: begin
                div_o = DW'(fld);
                ok_o  = (fld != '0);
            end
            ENC_POW2: begin
                ok_o  = (int'(fld) <= int'(DIV_W));
                div_o = ok_o ? (DW'(1) << fld) : DW'(1);
            end
            ENC_ZERO1: begin
                div_o = (fld == '0) ? DW'(1) : DW'(fld);
            end
            ENC_LOOKUP: begin
                div_o = tbl_div;
                ok_o  = tbl_hit;
            end
            default: begin
                div_o = DW'(fld) + DW'(1);
            end
        endcase
    end

endmodule

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
    import clkdiv_pkg::*;
#(
    parameter int unsigned AW    = 4,
    parameter int unsigned DIV_W = 8,
    parameter int unsigned TBL_N = 8,
    parameter int unsigned SHIFT = 4,
    parameter logic [31:0] MASK  = 32'h0000_00FF,
    localparam int unsigned DW   = DIV_W + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [31:0]   wr_data_i,
    input  logic [2:0]    mode_i,
    output logic [DW-1:0] pend_o,
    output logic          err_o
);

    typedef struct packed {
        logic [TBL_N-1:0]            vld;
        logic [TBL_N-1:0][DIV_W-1:0] fld;
        logic [TBL_N-1:0][DW-1:0]    dv;
        logic [DW-1:0]               pend;
        logic                        err;
    } cfg_t;

    cfg_t             s_d, s_q;
    logic [DW-1:0]    dec_div;
    logic             dec_ok;
    logic [TBL_N-1:0] ent_sel;
    logic             ctl_sel;

    assign ctl_sel = wr_en_i && (wr_addr_i == '0);

    for (genvar g = 0; g < TBL_N; g++) begin : g_sel
        assign ent_sel[g] = wr_en_i && (wr_addr_i == AW'(g + 1));
    end

    clkdiv_decode #(
        .DIV_W (DIV_W),
        .TBL_N (TBL_N),
        .SHIFT (SHIFT),
        .MASK  (MASK)
    ) u_decode (
        .ctrl_i (wr_data_i),
        .mode_i (mode_i),
        .vld_i  (s_q.vld),
        .fld_i  (s_q.fld),
        .dv_i   (s_q.dv),
        .div_o  (dec_div),
        .ok_o   (dec_ok)
    );

    always_comb begin
        s_d = s_q;
        if (ctl_sel) begin
            if (dec_ok) begin
                s_d.pend = dec_div;
            end else begin
                s_d.err = 1'b1;
            end
        end
        for (int i = 0; i < TBL_N; i++) begin
            if (ent_sel[i]) begin
                s_d.vld[i] = wr_data_i[TBL_VLD_BIT];
                s_d.fld[i] = wr_data_i[DIV_W-1:0];
                s_d.dv[i]  = wr_data_i[TBL_DIV_LSB +: DW];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.pend <= DW'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
    assign err_o  = s_q.err;

    // R8
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    // R11
    pend_only_on_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(s_q.pend) |-> $past(wr_en_i && (wr_addr_i == '0)));

    // R7
    pend_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.pend != '0);

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
    parameter int unsigned DW = 9
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] pend_i,
    output logic          clk_o
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] div;
        logic          out;
    } core_t;

    core_t s_d, s_q;
    logic  last;

    assign last = (s_q.cnt >= (s_q.div - DW'(1)));

    always_comb begin
        s_d = s_q;
        if (last) begin
            s_d.cnt = '0;
            s_d.div = pend_i;
        end else begin
            s_d.cnt = s_q.cnt + DW'(1);
        end
        s_d.out = (s_d.cnt < (s_d.div >> 1));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.cnt <= '0;
            s_q.div <= DW'(1);
            s_q.out <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // Divide-by-1 passes the source clock; otherwise the registered phase
    assign clk_o = (s_q.div == DW'(1)) ? clk_i : s_q.out;

    // R9
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt < s_q.div);

    // R10
    div_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(s_q.div) |-> ($past(s_q.cnt) == ($past(s_q.div) - DW'(1))));

    // R10
    start_of_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(s_q.div) |-> (s_q.cnt == '0));

endmodule

// File: rtl/prog_clk_div.sv
module prog_clk_div #(
    parameter int unsigned AW    = 4,
    parameter int unsigned DIV_W = 8,
    parameter int unsigned TBL_N = 8,
    parameter int unsigned SHIFT = 4,
    parameter logic [31:0] MASK  = 32'h0000_00FF
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [31:0]   wr_data_i,
    input  logic [2:0]    mode_i,
    output logic          clk_o,
    output logic          err_o
);

    localparam int unsigned DW = DIV_W + 1;

    logic [DW-1:0] pend;

    clkdiv_cfg #(
        .AW    (AW),
        .DIV_W (DIV_W),
        .TBL_N (TBL_N),
        .SHIFT (SHIFT),
        .MASK  (MASK)
    ) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .mode_i    (mode_i),
        .pend_o    (pend),
        .err_o     (err_o)
    );

    clkdiv_core #(
        .DW (DW)
    ) u_core (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pend_i (pend),
        .clk_o  (clk_o)
    );

endmodule

// File: tb/prog_clk_div_tb.sv
module prog_clk_div_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  mode = '0;
    logic        clk_out;
    logic        err;

    int checks = 0;
    int fails  = 0;
    int cur_div = 1;

    always #4 clk = ~clk;

    prog_clk_div u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .mode_i    (mode),
        .clk_o     (clk_out),
        .err_o     (err)
    );

    // {mode[2:0], field[7:0], expected divisor[8:0]}
    localparam int NV = 20;
    localparam logic [19:0] VEC [NV] = '{
        {3'd0, 8'd0,   9'd1},   {3'd0, 8'd1,   9'd2},   {3'd0, 8'd2,   9'd3},
        {3'd0, 8'd6,   9'd7},   {3'd0, 8'd255, 9'd256}, {3'd5, 8'd3,   9'd4},
        {3'd7, 8'd4,   9'd5},   {3'd1, 8'd1,   9'd1},   {3'd1, 8'd5,   9'd5},
        {3'd1, 8'd4,   9'd4},   {3'd2, 8'd0,   9'd1},   {3'd2, 8'd1,   9'd2},
        {3'd2, 8'd3,   9'd8},   {3'd2, 8'd8,   9'd256}, {3'd3, 8'd0,   9'd1},
        {3'd3, 8'd1,   9'd1},   {3'd3, 8'd3,   9'd3},   {3'd4, 8'd0,   9'd4},
        {3'd4, 8'd1,   9'd8},   {3'd4, 8'd5,   9'd3}
    };

    task automatic report(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [2:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; mode = m;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2: junk outside bits [11:4] must not matter
    task automatic set_div(input logic [2:0] m, input logic [7:0] f);
        wr(4'd0, 32'hA000_500F | (32'(f) << 4), m);
    endtask

    task automatic settle();
        repeat (2 * cur_div + 4) @(posedge clk);
    endtask

    task automatic sample(output logic v);
        @(posedge clk);
        #2 v = clk_out;
    endtask

    task automatic measure(output int per, output int hi);
        logic prev, cur;
        int k;
        per = 0; hi = 0;
        sample(prev);
        k = 0;
        sample(cur);
        while (!(prev == 1'b0 && cur == 1'b1) && k < 1200) begin
            prev = cur; sample(cur); k++;
        end
        do begin
            per++; hi += int'(cur); prev = cur; sample(cur);
        end while (!(prev == 1'b0 && cur == 1'b1) && per < 700);
    endtask

    task automatic check_div(input int exp, input string tag);
        int per, hi;
        logic a, b;
        bit ok;
        if (exp == 1) begin
            ok = 1'b1;
            for (int i = 0; i < 8; i++) begin
                @(posedge clk);
                #2 a = clk_out;
                #4 b = clk_out;
                if (a !== 1'b1 || b !== 1'b0) ok = 1'b0;
            end
            report(ok, {tag, " passthrough"}, ok ? 1 : 0, 1);
        end else begin
            measure(per, hi);
            report(per == exp, {tag, " period"}, per, exp);
            report(hi == exp / 2, {tag, " high phase R9"}, hi, exp / 2);
        end
    endtask

    function automatic string mtag(input logic [2:0] m);
        case (m)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cur_div = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1
        report(err == 1'b0, "R1 err after reset", int'(err), 0);
        check_div(1, "R1 reset divisor");

        // Table load, R7 format: {valid[31], div[24:16], field[7:0]}
        wr(4'd1, 32'h8004_0000, 3'd0);   // field 0 -> 4
        wr(4'd2, 32'h8008_0001, 3'd0);   // field 1 -> 8
        wr(4'd3, 32'h8003_0005, 3'd0);   // field 5 -> 3
        wr(4'd4, 32'h8006_0000, 3'd0);   // duplicate field 0 -> 6, lower priority
        wr(4'd5, 32'h0005_0009, 3'd0);   // not valid
        wr(4'd6, 32'h8000_000A, 3'd0);   // divisor 0

        for (int v = 0; v < NV; v++) begin
            set_div(VEC[v][19:17], VEC[v][16:9]);
            settle();
            check_div(int'(VEC[v][8:0]), mtag(VEC[v][19:17]));
            cur_div = int'(VEC[v][8:0]);
        end
        report(err == 1'b0, "R3 no error on legal words", int'(err), 0);

        // R11: ignored address, then R8 miss on field 7
        wr(4'd12, 32'h8002_0007, 3'd0);
        set_div(3'd4, 8'd7);
        report(err == 1'b1, "R8 err on table miss", int'(err), 1);
        settle();
        check_div(3, "R11 R8 divisor kept");
        set_div(3'd4, 8'd9);
        settle();
        check_div(3, "R7 invalid entry no match");
        set_div(3'd4, 8'd10);
        settle();
        check_div(3, "R7 zero-divisor entry no match");
        report(err == 1'b1, "R8 err sticky", int'(err), 1);

        do_reset();
        report(err == 1'b0, "R1 err cleared", int'(err), 0);
        set_div(3'd0, 8'd4);
        settle();
        cur_div = 5;
        set_div(3'd1, 8'd0);
        report(err == 1'b1, "R4 zero rejected err", int'(err), 1);
        settle();
        check_div(5, "R4 zero rejected kept");

        do_reset();
        set_div(3'd2, 8'd9);
        report(err == 1'b1, "R5 large exponent err", int'(err), 1);
        settle();
        check_div(1, "R5 large exponent kept");

        // R10: change from 8 to 2 mid period
        do_reset();
        set_div(3'd2, 8'd3);
        settle();
        cur_div = 8;
        settle();
        repeat (3) @(posedge clk);
        begin
            logic prev, cur;
            int run, nruns;
            bit ok;
            ok = 1'b1; run = 0; nruns = 0;
            set_div(3'd0, 8'd1);
            sample(prev);
            for (int i = 0; i < 60; i++) begin
                sample(cur);
                if (cur == prev) begin
                    run++;
                end else begin
                    if (nruns > 0 && run + 1 != 4 && run + 1 != 1) ok = 1'b0;
                    nruns++;
                    run = 0;
                end
                prev = cur;
            end
            report(ok && nruns > 4, "R10 phase lengths across change", nruns, 5);
        end
        check_div(2, "R10 new divisor");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule